// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This unit sits on a simple memory-mapped bus next to one processor core and produces that core's machine-level timer and software interrupt lines. It contains a free-running 64-bit tick counter, a 64-bit alarm register and a one-bit software interrupt flag. The timer interrupt is raised for as long as the counter has reached or passed the alarm value. The software interrupt follows the flag. The counter value is also driven out of the block so that a separate supervisor-level alarm elsewhere can be compared against the same time base.

Software reaches the 64-bit registers either one 32-bit word at a time, with the low word at the register's offset and the high word four bytes above it, or as a single 64-bit doubleword at the register's offset. The alarm leaves reset at its maximum value, so no timer interrupt is pending after reset. Software dismisses a timer interrupt by rewriting the alarm to its maximum. There is no acknowledge bit.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset the counter is zero, the alarm holds all ones and the software flag is zero, so `timer_irq` and `soft_irq` are both low.
- R2: The counter rises by one on every clock edge at which `tick_en` is high and no write hits it. It holds when `tick_en` is low, and it wraps from all ones to zero.
- R3: `timer_irq` is high exactly when the counter is greater than or equal to the alarm, as an unsigned 64-bit comparison. The output follows the registers with no extra delay, so it is valid in the cycle after either register is updated.
- R4: Writing all ones into the alarm, either as one doubleword or as two words, drops `timer_irq`, provided the counter is below all ones.
- R5: A word access (`req_dword`=0) at offset 0x4000 (alarm) or 0xBFF8 (counter) reaches the low half, and one at 0x4004 or 0xBFFC reaches the high half. Word write data is taken from `req_wdata[31:0]`. Word reads return the half in `rsp_rdata[31:0]` with bits 63:32 zero. The other half is left unchanged.
- R6: A doubleword access (`req_dword`=1) at 0x4000 or 0xBFF8 writes or reads all 64 bits in one request.
- R7: The software flag is at offset 0x0000. A write there stores `req_wdata[0]`, and `soft_irq` equals the stored bit. A read returns that bit in `rsp_rdata[0]` with every other bit zero.
- R8: Any other offset/size combination is unmapped. This includes word 0x0004, doubleword 0x4004 and any offset not aligned to four bytes. Reads there return zero, and writes there change no register.
- R9: When a write hits the counter in the same cycle that `tick_en` is high, the write wins. The written half takes the new data, the unwritten half keeps its old value, and no increment happens in that cycle.
- R10: `time_value` always equals the counter.
- R11: Each read request produces exactly one `rsp_valid` pulse, on the clock edge after the request is taken, carrying the data held before that edge. Write requests produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter increment enable for this cycle |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | 16 | Byte offset from the unit base |
| req_wdata | input | 64 | Write data; words use bits 31:0 |
| rsp_valid | output | 1 | Read response pulse |
| rsp_rdata | output | 64 | Read response data |
| time_value | output | 64 | Current counter value |
| timer_irq | output | 1 | Machine timer interrupt |
| soft_irq | output | 1 | Machine software interrupt |

## Verification
Two things can land in the same cycle: a software write to the counter and a counting tick. The bench raises `tick_en` in the very cycle that a word or doubleword write to the counter is presented. It then expects exactly the written data in the written half, the untouched half unchanged, and no +1 anywhere. A second overlap is an alarm rewrite taking effect while the counter sits above the old alarm. The bench judges this by sampling `timer_irq` one cycle after the write and requiring that it has fallen.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned DWORD_W = 2 * WORD_W;
    localparam int unsigned OFS_W   = 16;

    localparam logic [OFS_W-1:0] DEF_FLAG_OFS  = 16'h0000;
    localparam logic [OFS_W-1:0] DEF_ALARM_OFS = 16'h4000;
    localparam logic [OFS_W-1:0] DEF_COUNT_OFS = 16'hBFF8;

    // One-hot target plus half selects for 64-bit targets
    typedef struct packed {
        logic flag;
        logic alarm;
        logic count;
        logic lo;
        logic hi;
    } sel_t;

    // Aligns bus write data so both halves of a 64-bit register see the
    // correct lane: words replicate bits 31:0 to both halves.
    function automatic logic [DWORD_W-1:0] lane_data(
        input logic [DWORD_W-1:0] wdata,
        input logic               dword
    );
        return dword ? wdata : {wdata[WORD_W-1:0], wdata[WORD_W-1:0]};
    endfunction

    // Zero-extended selection of one half or the full value for reads.
    function automatic logic [DWORD_W-1:0] read_view(
        input logic [DWORD_W-1:0] val,
        input logic               lo,
        input logic               hi
    );
        logic [DWORD_W-1:0] r;
        r = '0;
        if (lo && hi)  r = val;
        else if (lo)   r[WORD_W-1:0] = val[WORD_W-1:0];
        else if (hi)   r[WORD_W-1:0] = val[DWORD_W-1:WORD_W];
        return r;
    endfunction

endpackage

// File: rtl/tmr_irq_decode.sv
module tmr_irq_decode
    import tmr_irq_pkg::*;
#(
    parameter int unsigned      AW        = OFS_W,
    parameter logic [AW-1:0]    FLAG_OFS  = DEF_FLAG_OFS,
    parameter logic [AW-1:0]    ALARM_OFS = DEF_ALARM_OFS,
    parameter logic [AW-1:0]    COUNT_OFS = DEF_COUNT_OFS
) (
    input  logic [AW-1:0] addr,
    input  logic          dword,
    output sel_t          sel
);
    localparam logic [AW-1:0] HALF_STEP = AW'(WORD_W / 8);

    always_comb begin
        sel = '0;
        if (addr == FLAG_OFS) begin
            sel.flag = 1'b1;
            sel.lo   = 1'b1;
        end
        if (dword) begin
            if (addr == ALARM_OFS) begin
                sel.alarm = 1'b1; sel.lo = 1'b1; sel.hi = 1'b1;
            end
            if (addr == COUNT_OFS) begin
                sel.count = 1'b1; sel.lo = 1'b1; sel.hi = 1'b1;
            end
        end else begin
            if (addr == ALARM_OFS) begin
                sel.alarm = 1'b1; sel.lo = 1'b1;
            end
            if (addr == ALARM_OFS + HALF_STEP) begin
                sel.alarm = 1'b1; sel.hi = 1'b1;
            end
            if (addr == COUNT_OFS) begin
                sel.count = 1'b1; sel.lo = 1'b1;
            end
            if (addr == COUNT_OFS + HALF_STEP) begin
                sel.count = 1'b1; sel.hi = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_irq_split_reg.sv
module tmr_irq_split_reg #(
    parameter int unsigned   W       = 64,
    parameter logic [W-1:0]  RST_VAL = '0,
    parameter bit            COUNTS  = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam int unsigned H = W / 2;

    logic [W-1:0] step_val;

    generate
        if (COUNTS) begin : g_count
            always_comb step_val = q + W'(1);
        end else begin : g_hold
            always_comb step_val = q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) q[H-1:0] <= wdata[H-1:0];
            if (wr_hi) q[W-1:H] <= wdata[W-1:H];
        end else if (step) begin
            q <= step_val;
        end
    end

endmodule

// File: rtl/tmr_irq_rdport.sv
module tmr_irq_rdport
    import tmr_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_req,
    input  sel_t               sel,
    input  logic               flag,
    input  logic [DWORD_W-1:0] alarm,
    input  logic [DWORD_W-1:0] count,
    output logic               rsp_valid,
    output logic [DWORD_W-1:0] rsp_rdata
);
    logic [DWORD_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (sel.flag)       rd_mux = {{(DWORD_W-1){1'b0}}, flag};
        else if (sel.alarm) rd_mux = read_view(alarm, sel.lo, sel.hi);
        else if (sel.count) rd_mux = read_view(count, sel.lo, sel.hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) rsp_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
    import tmr_irq_pkg::*;
#(
    parameter int unsigned       AW        = OFS_W,
    parameter logic [AW-1:0]     FLAG_OFS  = DEF_FLAG_OFS,
    parameter logic [AW-1:0]     ALARM_OFS = DEF_ALARM_OFS,
    parameter logic [AW-1:0]     COUNT_OFS = DEF_COUNT_OFS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_dword,
    input  logic [AW-1:0]      req_addr,
    input  logic [DWORD_W-1:0] req_wdata,
    output logic               rsp_valid,
    output logic [DWORD_W-1:0] rsp_rdata,
    output logic [DWORD_W-1:0] time_value,
    output logic               timer_irq,
    output logic               soft_irq
);
    sel_t               sel;
    logic               wr_go;
    logic               rd_go;
    logic [DWORD_W-1:0] wlane;
    logic [DWORD_W-1:0] alarm_q;
    logic [DWORD_W-1:0] count_q;
    logic               flag_q;

    assign wr_go = req_valid &&  req_write;
    assign rd_go = req_valid && !req_write;
    assign wlane = lane_data(req_wdata, req_dword);

    tmr_irq_decode #(
        .AW(AW), .FLAG_OFS(FLAG_OFS), .ALARM_OFS(ALARM_OFS), .COUNT_OFS(COUNT_OFS)
    ) u_decode (
        .addr  (req_addr),
        .dword (req_dword),
        .sel   (sel)
    );

    tmr_irq_split_reg #(
        .W(DWORD_W), .RST_VAL({DWORD_W{1'b1}}), .COUNTS(1'b0)
    ) u_alarm (
        .clk   (clk),
        .rst   (rst),
        .step  (1'b0),
        .wr_lo (wr_go && sel.alarm && sel.lo),
        .wr_hi (wr_go && sel.alarm && sel.hi),
        .wdata (wlane),
        .q     (alarm_q)
    );

    tmr_irq_split_reg #(
        .W(DWORD_W), .RST_VAL('0), .COUNTS(1'b1)
    ) u_count (
        .clk   (clk),
        .rst   (rst),
        .step  (tick_en),
        .wr_lo (wr_go && sel.count && sel.lo),
        .wr_hi (wr_go && sel.count && sel.hi),
        .wdata (wlane),
        .q     (count_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                   flag_q <= 1'b0;
        else if (wr_go && sel.flag) flag_q <= req_wdata[0];
    end

    tmr_irq_rdport u_rdport (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_go),
        .sel       (sel),
        .flag      (flag_q),
        .alarm     (alarm_q),
        .count     (count_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign time_value = count_q;
    assign timer_irq  = (count_q >= alarm_q);
    assign soft_irq   = flag_q;

endmodule

// File: rtl/tmr_irq_checker.sv
module tmr_irq_checker
    import tmr_irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tick_en,
    input logic               req_valid,
    input logic               req_write,
    input logic               req_dword,
    input logic [OFS_W-1:0]   req_addr,
    input logic [DWORD_W-1:0] req_wdata,
    input logic               rsp_valid,
    input logic [DWORD_W-1:0] rsp_rdata,
    input logic [DWORD_W-1:0] time_value,
    input logic               timer_irq,
    input logic               soft_irq
);
    logic any_wr;
    assign any_wr = req_valid && req_write;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (time_value == '0 && !timer_irq && !soft_irq));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick_en && !any_wr))
            |-> time_value == $past(time_value) + 64'd1);

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!tick_en && !any_wr)) |-> $stable(time_value));

    p_irq_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(timer_irq && !any_wr && time_value != '1))
            |-> timer_irq);

    p_alarm_max_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(any_wr && req_dword && req_addr == DEF_ALARM_OFS
                              && req_wdata == '1) && time_value != '1)
            |-> !timer_irq);

    p_flag_bit_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(any_wr && req_addr == DEF_FLAG_OFS))
            |-> soft_irq == $past(req_wdata[0]));

    p_unaligned_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid && !req_write && req_addr[1:0] != 2'b00))
            |-> rsp_rdata == '0);

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rsp_valid == $past(req_valid && !req_write));

endmodule

bind tmr_irq_unit tmr_irq_checker u_chk (.*);

// File: tb/tmr_irq_unit_bench.sv
`timescale 1ns/1ps
module tmr_irq_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_dword = 1'b0;
    logic [15:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [63:0] time_value;
    logic        timer_irq;
    logic        soft_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    tmr_irq_unit u_tmr_irq_unit (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .req_valid(req_valid), .req_write(req_write), .req_dword(req_dword),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .time_value(time_value), .timer_irq(timer_irq), .soft_irq(soft_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data as responses arrive
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk("R11 unexpected response", 64'd1, 64'd0);
                end else begin
                    chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic bus_write(input logic [15:0] a, input logic dw, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_dword = dw;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic dw,
                            input logic [63:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_dword = dw; req_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 counter", time_value, 64'd0);
        chk("R1 timer_irq", {63'd0, timer_irq}, 64'd0);
        chk("R1 soft_irq", {63'd0, soft_irq}, 64'd0);
        bus_read(16'h4000, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R1 alarm reset (R6 dword read)");
        chk("R1 irq still low", {63'd0, timer_irq}, 64'd0);

        // R7 software flag
        bus_write(16'h0000, 1'b0, 64'hFFFF_FFFF);
        chk("R7 soft_irq set", {63'd0, soft_irq}, 64'd1);
        bus_read(16'h0000, 1'b0, 64'd1, "R7 flag read only bit0");
        bus_write(16'h0000, 1'b0, 64'h2);
        chk("R7 soft_irq clear", {63'd0, soft_irq}, 64'd0);
        bus_write(16'h0000, 1'b1, 64'h1);
        chk("R7 dword flag set", {63'd0, soft_irq}, 64'd1);

        // R5 word halves of the counter, R10 export
        bus_write(16'hBFF8, 1'b0, 64'hDEAD_0000_1111_2222);
        chk("R5 low word only", time_value, 64'h0000_0000_1111_2222);
        bus_write(16'hBFFC, 1'b0, 64'h3333_4444);
        chk("R10 time_value", time_value, 64'h3333_4444_1111_2222);
        bus_read(16'hBFFC, 1'b0, 64'h3333_4444, "R5 high word read");
        bus_read(16'hBFF8, 1'b0, 64'h1111_2222, "R5 low word read");
        bus_read(16'hBFF8, 1'b1, 64'h3333_4444_1111_2222, "R6 counter dword read");

        // R3 comparison boundary
        bus_write(16'h4000, 1'b1, 64'h3333_4444_1111_2230);
        chk("R3 below alarm", {63'd0, timer_irq}, 64'd0);
        tick(13);
        chk("R2 count 13", time_value, 64'h3333_4444_1111_222F);
        chk("R3 one below", {63'd0, timer_irq}, 64'd0);
        tick(1);
        chk("R3 equal", {63'd0, timer_irq}, 64'd1);
        tick(3);
        chk("R3 above", {63'd0, timer_irq}, 64'd1);

        // R4 dismissal by writing the maximum
        bus_write(16'h4000, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R4 dword max clears", {63'd0, timer_irq}, 64'd0);
        bus_write(16'h4000, 1'b0, 64'h0);
        chk("R5 alarm low word", {63'd0, timer_irq}, 64'd0);
        bus_write(16'h4004, 1'b0, 64'h0);
        chk("R5 alarm high word", {63'd0, timer_irq}, 64'd1);
        bus_read(16'h4000, 1'b1, 64'd0, "R6 alarm dword read");
        bus_write(16'h4000, 1'b0, 64'hFFFF_FFFF);
        bus_write(16'h4004, 1'b0, 64'hFFFF_FFFF);
        chk("R4 word max clears", {63'd0, timer_irq}, 64'd0);

        // R2 wrap
        bus_write(16'hBFF8, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
        tick(1);
        chk("R3 equal at max", {63'd0, timer_irq}, 64'd1);
        tick(1);
        chk("R2 wrap", time_value, 64'd0);
        chk("R2 wrap irq low", {63'd0, timer_irq}, 64'd0);
        repeat (5) @(negedge clk);
        chk("R2 hold", time_value, 64'd0);

        // R8 unmapped
        bus_write(16'h1000, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_write(16'h4004, 1'b1, 64'h0);
        bus_write(16'h0004, 1'b0, 64'h0);
        bus_write(16'hBFF9, 1'b0, 64'h55);
        chk("R8 counter untouched", time_value, 64'd0);
        chk("R8 flag untouched", {63'd0, soft_irq}, 64'd1);
        bus_read(16'h4000, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R8 alarm untouched");
        bus_read(16'h1000, 1'b1, 64'd0, "R8 unmapped read");
        bus_read(16'h4004, 1'b1, 64'd0, "R8 dword at high half");
        bus_read(16'h0004, 1'b0, 64'd0, "R8 word above flag");

        // R9 write versus tick in the same cycle
        bus_write(16'hBFF8, 1'b1, 64'h0000_0005_0000_0010);
        @(negedge clk);
        tick_en = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_dword = 1'b0;
        req_addr = 16'hBFF8; req_wdata = 64'h100;
        @(negedge clk);
        tick_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        chk("R9 write wins low", time_value, 64'h0000_0005_0000_0100);
        tick_en = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_dword = 1'b0;
        req_addr = 16'hBFFC; req_wdata = 64'h7;
        @(negedge clk);
        tick_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        chk("R9 write wins high", time_value, 64'h0000_0007_0000_0100);
        tick(2);
        chk("R9 counting resumes", time_value, 64'h0000_0007_0000_0102);

        repeat (3) @(negedge clk);
        chk("R11 all reads answered", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule